// File: doc/BRIEF.md
# Video Controller CPU Register Interface

This block sits between a host processor and the video memory of a tile-based display controller. The processor sees eight byte-wide register slots, selected by the low three bits of its address. Through these slots it sets the control and mask bytes, reads a status byte carrying the vertical-blank flag, loads the two scroll offsets, and loads a 14-bit video memory pointer. It then streams bytes into or out of video memory through a data port that steps the pointer after every access.

Video memory is an external synchronous RAM with one cycle of read latency. The block drives its address, write data and write enable, and it takes the read data back. Before an address reaches the RAM, the block folds it: the upper nametable alias is mapped onto the lower copy, and the palette window is reduced to its 32 real entries.

Data-port reads lag by one access through an internal buffer, except in palette space. A processor read request returns its byte in the clock cycle after the request.

Top module: `vidreg_if`

## Requirements
- R1: After reset, control, mask, the vblank flag, both scroll offsets, the memory pointer, the read buffer and the shared write toggle are all 0; vm_addr shows 0 and a status read returns 0x00.
- R2: A read request (cpu_cs=1, cpu_we=0) presents its byte on cpu_rdata during the following clock cycle. Slot 0 reads back control and slot 1 reads back mask. Slots 3, 4, 5 and 6 read as 0x00. Writes to slots 2, 3 and 4 change nothing.
- R3: Writes to slot 5 alternate: the write made with the toggle clear loads scroll_x, and the write made with the toggle set loads scroll_y. Every write to slot 5 or slot 6 flips the one toggle shared by both slots.
- R4: A write to slot 6 with the toggle clear loads data bits 5:0 into pointer bits 13:8. A write to slot 6 with the toggle set loads data into pointer bits 7:0.
- R5: A write to slot 7 asserts vm_we in the same cycle, with vm_wdata equal to the written byte and vm_addr equal to the folded pointer. The pointer then advances by 32 if control bit 2 is 1, and by 1 otherwise, wrapping within 14 bits.
- R6: A read of slot 7 with the pointer below 0x3F00 returns the buffer contents. The buffer is then reloaded from memory at the pointer, and the pointer advances as in R5.
- R7: A read of slot 7 with the pointer at or above 0x3F00 returns the memory byte at the folded pointer directly. The buffer is still reloaded and the pointer still advances.
- R8: A read of slot 2 returns the vblank flag in bit 7 and 0 in bits 6:0. It then clears the vblank flag and the shared toggle. If vblank_set is high in the same cycle, the flag stays set.
- R9: A vblank_set pulse sets the vblank flag in the next cycle.
- R10: Pointers 0x3000–0x3EFF reach vm_addr lowered by 0x1000. Pointers 0x3F00–0x3FFF reach vm_addr as 0x3F00 plus (pointer mod 32). All other pointers pass through unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_cs | input | 1 | Register access request this cycle |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 3 | Register slot |
| cpu_wdata | input | 8 | Write data |
| cpu_rdata | output | 8 | Read data, valid the cycle after a read request |
| vblank_set | input | 1 | Pulse that raises the vblank flag |
| vm_addr | output | 14 | Folded video memory address |
| vm_wdata | output | 8 | Video memory write data |
| vm_we | output | 1 | Video memory write enable |
| vm_rdata | input | 8 | Video memory read data, one cycle after vm_addr |
| ctrl_o | output | 8 | Control byte to the renderer |
| mask_o | output | 8 | Mask byte to the renderer |
| scroll_x | output | 8 | Horizontal scroll offset |
| scroll_y | output | 8 | Vertical scroll offset |

## Verification
Several properties are checked on every cycle. The toggle flips on each scroll or pointer write, and a status read clears both the toggle and the flag. A vblank pulse always sets the flag. The pointer steps by the amount the increment bit selects. The folded address never lands in the alias or the upper palette range. Only slot-7 writes raise the memory write enable. Control and status read returns are checked against the state one cycle earlier.

The one-access read lag, the palette bypass, and the memory contents produced by long streams of writes can only be shown by the bench's scenarios. The bench tracks these with its own model of memory and buffer over random and directed access sequences.

// File: rtl/vidreg_pkg.sv
`timescale 1ns/1ps
package vidreg_pkg;
   typedef enum logic [2:0] {
      SLOT_CTRL = 3'd0,
      SLOT_MASK = 3'd1,
      SLOT_STAT = 3'd2,
      SLOT_RSV3 = 3'd3,
      SLOT_RSV4 = 3'd4,
      SLOT_SCRL = 3'd5,
      SLOT_PTR  = 3'd6,
      SLOT_DATA = 3'd7
   } slot_e;
endpackage

// File: rtl/vidreg_regs.sv
`timescale 1ns/1ps
module vidreg_regs
   import vidreg_pkg::*;
#(
   parameter int DW       = 8,
   parameter int FLAG_BIT = 7
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_stb,
   input  logic          rd_stb,
   input  slot_e         sel,
   input  logic [DW-1:0] wdata,
   input  logic          vblank_set,
   output logic [DW-1:0] ctrl,
   output logic [DW-1:0] mask,
   output logic [DW-1:0] scroll_x,
   output logic [DW-1:0] scroll_y,
   output logic          vblank,
   output logic          ptr_hi_wr,
   output logic          ptr_lo_wr,
   output logic          data_wr,
   output logic          data_rd,
   output logic          stat_rd
);
   if (FLAG_BIT >= DW) begin : g_bad_flag
      $error("vidreg_regs: FLAG_BIT outside data width");
   end

   logic toggle;

   always_comb begin
      ptr_hi_wr = wr_stb && (sel == SLOT_PTR) && !toggle;
      ptr_lo_wr = wr_stb && (sel == SLOT_PTR) &&  toggle;
      data_wr   = wr_stb && (sel == SLOT_DATA);
      data_rd   = rd_stb && (sel == SLOT_DATA);
      stat_rd   = rd_stb && (sel == SLOT_STAT);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctrl     <= '0;
         mask     <= '0;
         scroll_x <= '0;
         scroll_y <= '0;
         toggle   <= 1'b0;
      end else if (wr_stb) begin
         case (sel)
            SLOT_CTRL: ctrl <= wdata;
            SLOT_MASK: mask <= wdata;
            SLOT_SCRL: begin
               if (toggle) scroll_y <= wdata;
               else        scroll_x <= wdata;
               toggle <= !toggle;
            end
            SLOT_PTR:  toggle <= !toggle;
            default: ;
         endcase
      end else if (stat_rd) begin
         toggle <= 1'b0;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)          vblank <= 1'b0;
      else if (vblank_set) vblank <= 1'b1;
      else if (stat_rd)    vblank <= 1'b0;
   end

   p_toggle_flip_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_stb && (sel == SLOT_SCRL || sel == SLOT_PTR)) |=> (toggle != $past(toggle)));
   p_stat_clears_toggle_r8: assert property (@(posedge clk) disable iff (!rst_n)
      stat_rd |=> !toggle);
   p_stat_clears_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_rd && !vblank_set) |=> !vblank);
   p_flag_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
      vblank_set |=> vblank);
endmodule

// File: rtl/vidreg_ptr.sv
`timescale 1ns/1ps
module vidreg_ptr #(
   parameter int VA_W        = 14,
   parameter int DW          = 8,
   parameter int ROW_STRIDE  = 32,
   parameter int PAL_ENTRIES = 32,
   parameter bit MIRROR_EN   = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            ptr_hi_wr,
   input  logic            ptr_lo_wr,
   input  logic [DW-1:0]   wdata,
   input  logic            step,
   input  logic            big_step,
   output logic [VA_W-1:0] phys,
   output logic            is_pal
);
   localparam int HI_W = VA_W - DW;
   localparam int PAL_IDX_W = $clog2(PAL_ENTRIES);
   localparam logic [VA_W-1:0] STEP_ONE = VA_W'(1);
   localparam logic [VA_W-1:0] STEP_BIG = VA_W'(ROW_STRIDE);
   localparam logic [VA_W-1:0] ALIAS_LO = VA_W'(14'h3000);
   localparam logic [VA_W-1:0] ALIAS_OF = VA_W'(14'h1000);
   localparam logic [VA_W-1:0] PAL_BASE = VA_W'(14'h3F00);
   localparam logic [VA_W-1:0] PAL_END  = PAL_BASE + VA_W'(PAL_ENTRIES);

   if (VA_W != 14) begin : g_bad_va
      $error("vidreg_ptr: memory map is laid out for a 14-bit pointer");
   end
   if (HI_W < 1 || HI_W > DW) begin : g_bad_split
      $error("vidreg_ptr: pointer must split into two data-width writes");
   end
   if ((1 << PAL_IDX_W) != PAL_ENTRIES) begin : g_bad_pal
      $error("vidreg_ptr: PAL_ENTRIES must be a power of two");
   end

   logic [VA_W-1:0] ptr;

   always_ff @(posedge clk) begin
      if (!rst_n)         ptr <= '0;
      else if (ptr_hi_wr) ptr <= {wdata[HI_W-1:0], ptr[DW-1:0]};
      else if (ptr_lo_wr) ptr <= {ptr[VA_W-1:DW], wdata};
      else if (step)      ptr <= ptr + (big_step ? STEP_BIG : STEP_ONE);
   end

   assign is_pal = (ptr >= PAL_BASE);

   if (MIRROR_EN) begin : g_fold
      always_comb begin
         if (ptr >= PAL_BASE)      phys = PAL_BASE + VA_W'(ptr[PAL_IDX_W-1:0]);
         else if (ptr >= ALIAS_LO) phys = ptr - ALIAS_OF;
         else                      phys = ptr;
      end
      p_fold_range_r10: assert property (@(posedge clk) disable iff (!rst_n)
         !((phys >= ALIAS_LO && phys < PAL_BASE) || phys >= PAL_END));
   end else begin : g_flat
      assign phys = ptr;
   end

   p_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !ptr_hi_wr && !ptr_lo_wr)
      |=> (ptr == $past(ptr) + ($past(big_step) ? STEP_BIG : STEP_ONE)));
endmodule

// File: rtl/vidreg_rdpath.sv
`timescale 1ns/1ps
module vidreg_rdpath
   import vidreg_pkg::*;
#(
   parameter int DW       = 8,
   parameter int FLAG_BIT = 7
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          rd_stb,
   input  slot_e         sel,
   input  logic          data_rd,
   input  logic          is_pal,
   input  logic [DW-1:0] ctrl,
   input  logic [DW-1:0] mask,
   input  logic          vblank,
   input  logic [DW-1:0] vm_rdata,
   output logic [DW-1:0] cpu_rdata
);
   localparam logic [DW-1:0] FLAG_MASK = DW'(1) << FLAG_BIT;

   logic [DW-1:0] reg_q;
   logic [DW-1:0] buf_q;
   logic          pend;
   logic          pend_pal;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         reg_q    <= '0;
         pend     <= 1'b0;
         pend_pal <= 1'b0;
      end else begin
         pend     <= data_rd;
         pend_pal <= data_rd && is_pal;
         if (rd_stb) begin
            case (sel)
               SLOT_CTRL: reg_q <= ctrl;
               SLOT_MASK: reg_q <= mask;
               SLOT_STAT: reg_q <= vblank ? FLAG_MASK : '0;
               default:   reg_q <= '0;
            endcase
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)    buf_q <= '0;
      else if (pend) buf_q <= vm_rdata;
   end

   assign cpu_rdata = pend ? (pend_pal ? vm_rdata : buf_q) : reg_q;

   p_ctrl_return_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_stb && sel == SLOT_CTRL) |=> (cpu_rdata == $past(ctrl)));
   p_stat_return_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_stb && sel == SLOT_STAT)
      |=> ((cpu_rdata[FLAG_BIT] == $past(vblank)) && ((cpu_rdata & ~FLAG_MASK) == '0)));
endmodule

// File: rtl/vidreg_if.sv
`timescale 1ns/1ps
module vidreg_if
   import vidreg_pkg::*;
#(
   parameter int DW          = 8,
   parameter int VA_W        = 14,
   parameter int ROW_STRIDE  = 32,
   parameter int PAL_ENTRIES = 32,
   parameter int INC_BIT     = 2,
   parameter int FLAG_BIT    = 7,
   parameter bit MIRROR_EN   = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            cpu_cs,
   input  logic            cpu_we,
   input  logic [2:0]      cpu_addr,
   input  logic [DW-1:0]   cpu_wdata,
   output logic [DW-1:0]   cpu_rdata,
   input  logic            vblank_set,
   output logic [VA_W-1:0] vm_addr,
   output logic [DW-1:0]   vm_wdata,
   output logic            vm_we,
   input  logic [DW-1:0]   vm_rdata,
   output logic [DW-1:0]   ctrl_o,
   output logic [DW-1:0]   mask_o,
   output logic [DW-1:0]   scroll_x,
   output logic [DW-1:0]   scroll_y
);
   if (INC_BIT >= DW) begin : g_bad_inc
      $error("vidreg_if: INC_BIT outside data width");
   end

   logic  wr_stb, rd_stb;
   slot_e sel;
   logic  ptr_hi_wr, ptr_lo_wr, data_wr, data_rd, stat_rd;
   logic  vblank, is_pal;

   assign wr_stb = cpu_cs &&  cpu_we;
   assign rd_stb = cpu_cs && !cpu_we;
   assign sel    = slot_e'(cpu_addr);

   vidreg_regs #(.DW(DW), .FLAG_BIT(FLAG_BIT)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .rd_stb(rd_stb), .sel(sel),
      .wdata(cpu_wdata), .vblank_set(vblank_set), .ctrl(ctrl_o), .mask(mask_o),
      .scroll_x(scroll_x), .scroll_y(scroll_y), .vblank(vblank),
      .ptr_hi_wr(ptr_hi_wr), .ptr_lo_wr(ptr_lo_wr), .data_wr(data_wr),
      .data_rd(data_rd), .stat_rd(stat_rd));

   vidreg_ptr #(.VA_W(VA_W), .DW(DW), .ROW_STRIDE(ROW_STRIDE),
                .PAL_ENTRIES(PAL_ENTRIES), .MIRROR_EN(MIRROR_EN)) u_ptr (
      .clk(clk), .rst_n(rst_n), .ptr_hi_wr(ptr_hi_wr), .ptr_lo_wr(ptr_lo_wr),
      .wdata(cpu_wdata), .step(data_wr || data_rd), .big_step(ctrl_o[INC_BIT]),
      .phys(vm_addr), .is_pal(is_pal));

   vidreg_rdpath #(.DW(DW), .FLAG_BIT(FLAG_BIT)) u_rd (
      .clk(clk), .rst_n(rst_n), .rd_stb(rd_stb), .sel(sel), .data_rd(data_rd),
      .is_pal(is_pal), .ctrl(ctrl_o), .mask(mask_o), .vblank(vblank),
      .vm_rdata(vm_rdata), .cpu_rdata(cpu_rdata));

   assign vm_wdata = cpu_wdata;
   assign vm_we    = data_wr;

   p_we_only_data_r5: assert property (@(posedge clk) disable iff (!rst_n)
      vm_we |-> (cpu_cs && cpu_we && cpu_addr == 3'd7));
endmodule

// File: tb/tb_vidreg_if.sv
`timescale 1ns/1ps
module tb_vidreg_if;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cpu_cs = 1'b0, cpu_we = 1'b0, vblank_set = 1'b0;
   logic [2:0]  cpu_addr = '0;
   logic [7:0]  cpu_wdata = '0, cpu_rdata;
   logic [13:0] vm_addr;
   logic [7:0]  vm_wdata, vm_rdata, ctrl_o, mask_o, scroll_x, scroll_y;
   logic        vm_we;

   always #5 clk = ~clk;

   vidreg_if dut (.clk(clk), .rst_n(rst_n), .cpu_cs(cpu_cs), .cpu_we(cpu_we),
      .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
      .vblank_set(vblank_set), .vm_addr(vm_addr), .vm_wdata(vm_wdata),
      .vm_we(vm_we), .vm_rdata(vm_rdata), .ctrl_o(ctrl_o), .mask_o(mask_o),
      .scroll_x(scroll_x), .scroll_y(scroll_y));

   // synchronous RAM, 2048 bytes indexed by address bits 10:0
   logic [7:0] ram [0:2047];
   always_ff @(posedge clk) begin
      if (vm_we) ram[vm_addr[10:0]] <= vm_wdata;
      vm_rdata <= ram[vm_addr[10:0]];
   end

   // bench model
   logic [7:0]  mdl [0:2047];
   logic [7:0]  m_ctrl, m_mask, m_sx, m_sy, m_buf;
   logic        m_vb, m_tog;
   logic [13:0] m_ptr;
   int          nchk = 0, nerr = 0;
   bit          done = 1'b0;

   function automatic logic [13:0] fold(input logic [13:0] a);
      if (a >= 14'h3F00)      return 14'h3F00 + 14'(a % 32);
      else if (a >= 14'h3000) return a - 14'h1000;
      else                    return a;
   endfunction

   function automatic logic [13:0] next_ptr(input logic [13:0] a, input logic [7:0] c);
      return a + (c[2] ? 14'd32 : 14'd1);
   endfunction

   task automatic chk(input string tag, input int act, input int exp);
      nchk++;
      if (act != exp) begin
         nerr++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("Result: errors=%0d of %0d checks", nerr, nchk);
         $finish;
      end
   endtask

   // one access; entered and left at a falling edge
   task automatic op(input bit we, input logic [2:0] a, input logic [7:0] d, input bit vbs);
      logic [7:0] exp;
      string tag;
      exp = 8'h00;
      tag = "R2";
      cpu_cs = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = d; vblank_set = vbs;
      #1;
      if (a == 3'd7) begin
         chk("R10", vm_addr, fold(m_ptr));
         chk("R5", vm_we, we);
         if (we) chk("R5", vm_wdata, d);
      end
      if (we) begin
         case (a)
            3'd0: m_ctrl = d;
            3'd1: m_mask = d;
            3'd5: begin
               if (m_tog) m_sy = d; else m_sx = d;
               m_tog = !m_tog;
            end
            3'd6: begin
               if (m_tog) m_ptr[7:0] = d; else m_ptr[13:8] = d[5:0];
               m_tog = !m_tog;
            end
            3'd7: begin
               mdl[fold(m_ptr) & 14'h7FF] = d;
               m_ptr = next_ptr(m_ptr, m_ctrl);
            end
            default: ;
         endcase
      end else begin
         case (a)
            3'd0: exp = m_ctrl;
            3'd1: exp = m_mask;
            3'd2: begin
               exp = {m_vb, 7'b0};
               tag = "R8";
               m_vb = 1'b0;
               m_tog = 1'b0;
            end
            3'd7: begin
               if (m_ptr >= 14'h3F00) begin
                  tag = "R7";
                  exp = mdl[fold(m_ptr) & 14'h7FF];
               end else begin
                  tag = "R6";
                  exp = m_buf;
               end
               m_buf = mdl[fold(m_ptr) & 14'h7FF];
               m_ptr = next_ptr(m_ptr, m_ctrl);
            end
            default: exp = 8'h00;
         endcase
      end
      if (vbs) m_vb = 1'b1;
      @(posedge clk);
      @(negedge clk);
      if (!we) chk(tag, cpu_rdata, exp);
      if (we && a == 3'd5) begin
         chk("R3", scroll_x, m_sx);
         chk("R3", scroll_y, m_sy);
      end
      if (we) begin
         chk("R2", ctrl_o, m_ctrl);
         chk("R2", mask_o, m_mask);
      end
      cpu_cs = 1'b0; vblank_set = 1'b0;
   endtask

   task automatic set_ptr(input logic [13:0] p);
      if (m_tog) op(1'b0, 3'd2, 8'h00, 1'b0);
      op(1'b1, 3'd6, {2'b00, p[13:8]}, 1'b0);
      op(1'b1, 3'd6, p[7:0], 1'b0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      nerr++;
      $display("FAIL watchdog run did not complete");
      finish_run();
   end

   initial begin
      void'($urandom(32'd20240611));
      for (int i = 0; i < 2048; i++) mdl[i] = 8'h00;
      m_ctrl = 0; m_mask = 0; m_sx = 0; m_sy = 0; m_buf = 0;
      m_vb = 0; m_tog = 0; m_ptr = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1: reset state
      chk("R1", ctrl_o, 0);
      chk("R1", mask_o, 0);
      chk("R1", scroll_x, 0);
      chk("R1", scroll_y, 0);
      chk("R1", vm_addr, 0);
      op(1'b0, 3'd2, 8'h00, 1'b0);
      op(1'b0, 3'd7, 8'h00, 1'b0);   // R1: buffer starts at 0

      // fill the RAM through the data port, stride 1 from pointer 0
      set_ptr(14'h0000);
      for (int i = 0; i < 2048; i++) op(1'b1, 3'd7, 8'(i * 13 + 5), 1'b0);

      // R2: unused slots and ignored writes
      op(1'b1, 3'd3, 8'hA5, 1'b0);
      op(1'b1, 3'd4, 8'h5A, 1'b0);
      op(1'b1, 3'd2, 8'hFF, 1'b0);
      for (int s = 0; s < 7; s++) op(1'b0, 3'(s), 8'h00, 1'b0);

      // R4 and R6: one-access read lag
      set_ptr(14'h0123);
      op(1'b0, 3'd7, 8'h00, 1'b0);
      op(1'b0, 3'd7, 8'h00, 1'b0);
      op(1'b0, 3'd7, 8'h00, 1'b0);

      // R5: stride 32 and wrap at the top of the 14-bit space
      op(1'b1, 3'd0, 8'h04, 1'b0);
      set_ptr(14'h3FF0);
      op(1'b1, 3'd7, 8'h77, 1'b0);
      op(1'b1, 3'd7, 8'h78, 1'b0);
      op(1'b1, 3'd0, 8'h00, 1'b0);
      set_ptr(14'h3FFF);
      op(1'b1, 3'd7, 8'h99, 1'b0);
      op(1'b1, 3'd7, 8'h9A, 1'b0);

      // R7 and R10: palette window reads bypass the buffer
      set_ptr(14'h3F25);
      op(1'b0, 3'd7, 8'h00, 1'b0);
      op(1'b0, 3'd7, 8'h00, 1'b0);
      set_ptr(14'h3456);
      op(1'b1, 3'd7, 8'h3C, 1'b0);

      // R3: shared toggle across scroll and pointer writes
      op(1'b1, 3'd5, 8'h11, 1'b0);
      op(1'b1, 3'd6, 8'h22, 1'b0);
      op(1'b1, 3'd5, 8'h33, 1'b0);
      op(1'b0, 3'd2, 8'h00, 1'b0);
      op(1'b1, 3'd5, 8'h44, 1'b0);
      op(1'b1, 3'd5, 8'h55, 1'b0);

      // R9 and R8: flag set, cleared by a read, and set winning over the clear
      vblank_set = 1'b1;
      @(negedge clk);
      vblank_set = 1'b0;
      m_vb = 1'b1;
      op(1'b0, 3'd2, 8'h00, 1'b0);
      op(1'b0, 3'd2, 8'h00, 1'b1);
      op(1'b0, 3'd2, 8'h00, 1'b0);
      op(1'b0, 3'd2, 8'h00, 1'b0);

      // random traffic
      for (int n = 0; n < 3000; n++) begin
         int r;
         logic [7:0] d;
         r = int'($urandom % 20);
         d = 8'($urandom);
         if (r < 2) begin
            case ($urandom % 5)
               0: d = 8'h3F;
               1: d = 8'h3E;
               2: d = 8'h30;
               3: d = 8'h1F;
               default: ;
            endcase
            op(1'b1, 3'd6, d, 1'b0);
         end else if (r < 3) op(1'b1, 3'd0, d & 8'h04, 1'b0);
         else if (r < 7)  op(1'b1, 3'd7, d, ($urandom % 8) == 0);
         else if (r < 13) op(1'b0, 3'd7, 8'h00, ($urandom % 8) == 0);
         else if (r < 15) op(1'b0, 3'd2, 8'h00, ($urandom % 4) == 0);
         else if (r < 16) op(1'b1, 3'd5, d, 1'b0);
         else             op(1'($urandom), 3'($urandom), d, ($urandom % 8) == 0);
      end

      finish_run();
   end
endmodule